// File: doc/BRIEF.md
# DPCM Variable-Length Chunk Encoder

The block turns a stream of 16-bit signed audio samples into a stream of 5-bit symbols. For each accepted sample it takes the first-order prediction residual, the current sample minus the previously accepted one, and folds its sign into the least significant bit. For negative residuals the upper magnitude bits are inverted, so small residuals of either sign leave the high bits at zero.

The folded word goes out four payload bits at a time, low nibble first. The first symbol of every value carries a start flag. Continuation symbols follow only while the remaining shifted word is nonzero. A residual near zero therefore costs 5 bits and a full-scale residual costs 20 bits.

A receiver rebuilds each word from the start flag and the nibble order. Samples must arrive at least five clocks apart. Stereo decorrelation, the audio codec link and clock generation are handled elsewhere.

Top module: `dpcm_chunk_enc`

## Requirements
- R1: The residual is the sample minus the previously accepted sample, modulo 2^16. The previous-sample register takes the new sample on the edge that accepts it, and reset clears it to zero. The first sample after reset is therefore coded as its raw value.
- R2: For a residual with bit 15 clear, the coded word is residual bits [14:0] shifted up by one, with 0 in bit 0.
- R3: For a residual with bit 15 set, coded bits [15:4] are the inverse of residual bits [14:3], coded bits [3:1] are residual bits [2:0], and coded bit 0 is 1. A residual of -1 codes as 0x000F.
- R4: Symbol bit 4 is the start flag and bits [3:0] are the payload. In the clock after the accepting edge the block emits flag 1 with coded bits [3:0].
- R5: Each later symbol carries flag 0 and the next higher nibble of the coded word. Symbols come in consecutive clocks, and only while the part of the word not yet sent is nonzero.
- R6: Each value yields between 1 and 4 symbols: one more than the index of its highest nonzero nibble, or 1 if the word is zero. sym_valid_o is low in every clock without a symbol.
- R7: While reset is asserted and after its release, sym_valid_o is low until a sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe, at least 5 clocks apart |
| sample_i | input | 16 | Signed audio sample |
| sym_o | output | 5 | Bit 4 start flag, bits [3:0] payload nibble |
| sym_valid_o | output | 1 | sym_o holds a symbol this clock |

## Verification
The first symbol of a value is due in the clock right after the edge that accepts the sample. Each later symbol is due one clock after the one before it, and sym_valid_o must drop in the clock after the last one. The bench drives the strobe for one clock from a falling edge. It then samples on each following falling edge, rebuilds the word and counts the symbols until valid drops. It compares the count, the flags and the rebuilt word against a fold and a nibble count it works out arithmetically from its own record of the previous sample.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;
  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_NIBBLE_W = 4;
endpackage

// File: rtl/dpcm_residual.sv
module dpcm_residual #(
  parameter int unsigned SAMPLE_W = dpcm_pkg::DEF_SAMPLE_W,
  parameter int unsigned NIBBLE_W = dpcm_pkg::DEF_NIBBLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] coded_o
);
  logic [SAMPLE_W-1:0] prev_q;
  logic [SAMPLE_W-1:0] resid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             prev_q <= '0;
    else if (sample_valid_i) prev_q <= sample_i;
  end

  assign resid = sample_i - prev_q;

  // sign to bit 0; invert upper magnitude bits when negative
  always_comb begin
    if (resid[SAMPLE_W-1])
      coded_o = {~resid[SAMPLE_W-2:NIBBLE_W-1], resid[NIBBLE_W-2:0], 1'b1};
    else
      coded_o = {resid[SAMPLE_W-2:0], 1'b0};
  end

  a_r1_prev_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> prev_q == $past(sample_i));
  a_r2_pos_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !resid[SAMPLE_W-1]) |-> !coded_o[0]);
  a_r3_neg_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && resid[SAMPLE_W-1]) |-> coded_o[0]);
endmodule

// File: rtl/dpcm_chunker.sv
module dpcm_chunker #(
  parameter int unsigned SAMPLE_W = dpcm_pkg::DEF_SAMPLE_W,
  parameter int unsigned NIBBLE_W = dpcm_pkg::DEF_NIBBLE_W,
  localparam int unsigned SYM_W   = NIBBLE_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] word_i,
  output logic [SYM_W-1:0]    sym_o,
  output logic                sym_valid_o
);
  logic [SAMPLE_W-1:0] rem_q;
  logic [SYM_W-1:0]    sym_q;
  logic                vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      sym_q <= '0;
      vld_q <= 1'b0;
    end else if (load_i) begin
      sym_q <= {1'b1, word_i[NIBBLE_W-1:0]};
      rem_q <= word_i >> NIBBLE_W;
      vld_q <= 1'b1;
    end else if (rem_q != '0) begin
      sym_q <= {1'b0, rem_q[NIBBLE_W-1:0]};
      rem_q <= rem_q >> NIBBLE_W;
      vld_q <= 1'b1;
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign sym_o       = sym_q;
  assign sym_valid_o = vld_q;

  a_r4_start_sym: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> vld_q && sym_q[SYM_W-1]);
  a_r5_cont_sym: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && rem_q != '0) |=> vld_q && !sym_q[SYM_W-1]);
  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && rem_q == '0) |=> !vld_q);
endmodule

// File: rtl/dpcm_chunk_enc.sv
module dpcm_chunk_enc #(
  parameter int unsigned SAMPLE_W = dpcm_pkg::DEF_SAMPLE_W,
  parameter int unsigned NIBBLE_W = dpcm_pkg::DEF_NIBBLE_W,
  localparam int unsigned SYM_W   = NIBBLE_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SYM_W-1:0]    sym_o,
  output logic                sym_valid_o
);
  logic [SAMPLE_W-1:0] coded;

  dpcm_residual #(.SAMPLE_W(SAMPLE_W), .NIBBLE_W(NIBBLE_W)) u_resid (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sample_valid_i (sample_valid_i),
    .sample_i       (sample_i),
    .coded_o        (coded)
  );

  dpcm_chunker #(.SAMPLE_W(SAMPLE_W), .NIBBLE_W(NIBBLE_W)) u_chunk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (sample_valid_i),
    .word_i      (coded),
    .sym_o       (sym_o),
    .sym_valid_o (sym_valid_o)
  );

  a_r7_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !sym_valid_o);
endmodule

// File: tb/tb_dpcm_chunk_enc.sv
module tb_dpcm_chunk_enc;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic [4:0]  sym_o;
  logic        sym_valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] model_prev = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dpcm_chunk_enc dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_valid_i(sample_valid_i),
    .sample_i(sample_i), .sym_o(sym_o), .sym_valid_o(sym_valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fold(input logic [15:0] d);
    if (d[15]) fold = ((~d & 16'h7FF8) << 1) | ((d & 16'h0007) << 1) | 16'h0001;
    else       fold = d << 1;
  endfunction

  function automatic int nsym(input logic [15:0] w);
    nsym = 1;
    for (int i = 1; i < 4; i++) if ((w >> (4*i)) != 0) nsym = i + 1;
  endfunction

  task automatic send(input logic [15:0] s);
    logic [15:0] exp_w, got_w;
    int cnt;
    exp_w = fold(s - model_prev); // R1 residual; R2/R3 fold
    model_prev = s;
    @(negedge clk_i);
    sample_i = s; sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    got_w = '0; cnt = 0;
    for (int i = 0; i < 5; i++) begin
      if (!sym_valid_o) break;
      if (i == 0) chk(sym_o[4] == 1'b1, "R4 start flag", sym_o, 5'h10 | exp_w[3:0]);
      else        chk(sym_o[4] == 1'b0, "R5 continuation flag", sym_o, exp_w[4*i +: 4]);
      if (i < 4) got_w = got_w | (16'(sym_o[3:0]) << (4*i));
      cnt++;
      @(negedge clk_i);
    end
    chk(cnt == nsym(exp_w), "R6 symbol count", cnt, nsym(exp_w));
    chk(got_w == exp_w, exp_w[0] ? "R3 negative fold" : "R2 positive fold", got_w, exp_w);
  endtask

  initial begin
    repeat (400000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    chk(sym_valid_o == 1'b0, "R7 valid low in reset", sym_valid_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(sym_valid_o == 1'b0, "R7 valid low after reset", sym_valid_o, 0);
    // R1: first sample coded raw
    send(16'h1234);
    send(16'h1234);          // zero residual -> one symbol
    send(16'h1233);          // -1 -> 0x000F
    chk(fold(16'hFFFF) == 16'h000F, "R3 minus one code", fold(16'hFFFF), 16'h000F);
    // single-bit steps both signs
    for (int b = 0; b < 16; b++) begin
      send(model_prev + (16'h1 << b));
      send(model_prev - (16'h1 << b));
    end
    // dense sweep of small and medium residuals
    for (int d = -300; d <= 300; d++) send(model_prev + 16'(d));
    // pseudo-random walk
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr);
    end
    // R1: reset clears previous sample
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk(sym_valid_o == 1'b0, "R7 valid low on reset", sym_valid_o, 0);
    rst_ni = 1'b1; model_prev = '0;
    send(16'h8001);
    send(16'h7FFF);
    repeat (2) @(negedge clk_i);
    chk(sym_valid_o == 1'b0, "R6 idle low", sym_valid_o, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule